// File: doc/BRIEF.md
# Asynchronous Static-Memory Bus Controller

This block sits between an internal request port and an external asynchronous static memory bus of the SRAM or parallel-NOR kind. It also fits a display controller that takes commands and pixel data over a parallel strobe interface. The request carries a 32-bit byte address and 16-bit write data. The controller decodes the address into one of four fixed 64 MB windows starting at 0x6000_0000 and pulls that window's active-low chip select. It then runs a two-phase access: an address phase with only the chip select active, and a data phase in which the read strobe or the write strobe is low.

Each window has its own timing, given in system clocks:
- address-phase length;
- data-phase length;
- a quiet gap after the access;
- a bus width of 8 or 16 bits;
- an option that gives writes a timing pair separate from reads.

Because the external address lines come straight from the request address, a display's data/command select can be wired to one low address line. Software then reaches commands and data at two different addresses.

Top module: `xmc_top`

## Requirements
- R1: A request whose address has bits [31:26] equal to 0x18+k (k = 0..3) drives only `mem_ce_n[k]` low, for the whole access, with every other chip select high.
- R2: A request outside 0x6000_0000..0x6FFF_FFFF is answered one cycle after acceptance with `resp_valid`=1 and `resp_err`=1. No chip select, read strobe or write strobe goes low for it.
- R3: At most one bit of `mem_ce_n` is low in any cycle.
- R4: A read in window k keeps the chip select low for A+D+1 cycles. In the first A cycles both strobes are high. In the next D+1 cycles `mem_oe_n` is low. A and D are the window's read values in `cfg_rd_addset[4k+:4]` and `cfg_rd_datast[4k+:4]`, each 0..15.
- R5: A read captures `mem_dq_in` at the clock edge that ends the last strobe cycle. `resp_rdata` holds that value in the single cycle after the strobe rises, in which `resp_valid`=1 and `resp_err`=0.
- R6: A write holds `mem_we_n` low for D+1 cycles after the A address cycles. `mem_dq_drive` is high in exactly those cycles, and `mem_dq_out` holds the write data throughout. The response follows in the next cycle.
- R7: When `cfg_ext_wr[k]`=1, writes to window k take A and D from `cfg_wr_addset`/`cfg_wr_datast`. When it is 0, writes use the read pair and the write pair has no effect.
- R8: After an in-window access, `req_ready` stays low for exactly T cycles, counted from the response cycle, where T is `cfg_turn[4k+:4]`. A miss response adds no gap.
- R9: When `cfg_wide[k]`=1, `mem_a` is the request address bits [25:1] with a zero on top, and the full 16-bit bus is used. When `cfg_wide[k]`=0, `mem_a` is address bits [25:0], only the low 8 data bits are driven, and the read data returns with its upper byte zero.
- R10: During and right after reset, all chip selects and both strobes are high, the data bus is not driven, `req_ready`=1 and `resp_valid`=0.
- R11: `mem_oe_n` and `mem_we_n` are never low together. The data bus is never driven while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all phase lengths count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 16 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Address missed every window |
| resp_rdata | output | 16 | Read result |
| cfg_rd_addset | input | 16 | Per-window read address-phase length, 4 bits each |
| cfg_rd_datast | input | 16 | Per-window read data-phase length, 4 bits each |
| cfg_wr_addset | input | 16 | Per-window write address-phase length |
| cfg_wr_datast | input | 16 | Per-window write data-phase length |
| cfg_turn | input | 16 | Per-window quiet gap after an access |
| cfg_ext_wr | input | 4 | Per-window: writes use the write timing pair |
| cfg_wide | input | 4 | Per-window: 1 = 16-bit bus, 0 = 8-bit bus |
| mem_ce_n | output | 4 | Active-low chip selects, one per window |
| mem_a | output | 26 | External address |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_drive | output | 1 | Output enable of the data pad |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The bench goes after the zero-length address phase, the 15-clock maxima, the first and last byte of every window, and addresses one byte outside the whole range. A decoder off by one window, or one whose compare is too wide, lowers the wrong chip select or none, and the bench catches that through the chip-select pattern and the error flag. A sequencer that loads the counter with the raw count instead of count minus one gives phases one cycle long or short, and the measured strobe and pre-strobe lengths show it. So does one that reads the wrong timing pair on writes. Sampling read data one edge late returns the idle value of the memory model instead of its data. Shifting the address on the 8-bit windows, or leaving the upper byte set there, shows up on `mem_a` and on the returned data.

// File: rtl/xmc_pkg.sv
package xmc_pkg;

   // width of every programmable phase count
   localparam int unsigned TW = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2,
      ST_TURN = 2'd3
   } xmc_state_e;

endpackage

// File: rtl/xmc_decode.sv
module xmc_decode #(
   parameter int                ADDR_W   = 32,
   parameter int                NBANK    = 4,
   parameter int                WIN_BITS = 26,
   parameter int                BIDX_W   = 2,
   parameter logic [ADDR_W-1:0] BASE     = 32'h6000_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NBANK-1:0]  hit_vec,
   output logic [BIDX_W-1:0] bank_idx,
   output logic              hit
);
   localparam int TAG_W = ADDR_W - WIN_BITS;
   localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:WIN_BITS];

   if (BASE[WIN_BITS-1:0] != '0) begin : g_chk_align
      $error("window base must be aligned to the window size");
   end
   if (int'(BASE_TAG) + NBANK > (1 << TAG_W)) begin : g_chk_wrap
      $error("windows run past the top of the address space");
   end

   // one tag comparator per window
   for (genvar g = 0; g < NBANK; g++) begin : g_win
      localparam logic [TAG_W-1:0] TAG_G = BASE_TAG + TAG_W'(g);
      assign hit_vec[g] = (addr[ADDR_W-1:WIN_BITS] == TAG_G);
   end

   always_comb begin
      bank_idx = '0;
      for (int i = 0; i < NBANK; i++) begin
         if (hit_vec[i]) bank_idx = BIDX_W'(i);
      end
   end

   assign hit = |hit_vec;

endmodule

// File: rtl/xmc_tsel.sv
module xmc_tsel #(
   parameter int NBANK       = 4,
   parameter int BIDX_W      = 2,
   parameter int TW          = 4,
   parameter bit EXT_SUPPORT = 1'b1
) (
   input  logic [BIDX_W-1:0]   bank_idx,
   input  logic                is_write,
   input  logic [NBANK*TW-1:0] rd_as,
   input  logic [NBANK*TW-1:0] rd_ds,
   input  logic [NBANK*TW-1:0] wr_as,
   input  logic [NBANK*TW-1:0] wr_ds,
   input  logic [NBANK*TW-1:0] turn,
   input  logic [NBANK-1:0]    ext_en,
   input  logic [NBANK-1:0]    wide,
   output logic [TW-1:0]       sel_as,
   output logic [TW-1:0]       sel_ds,
   output logic [TW-1:0]       sel_turn,
   output logic                sel_wide
);
   logic [TW-1:0] as_arr   [NBANK];
   logic [TW-1:0] ds_arr   [NBANK];
   logic [TW-1:0] turn_arr [NBANK];

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      if (EXT_SUPPORT) begin : g_ext
         logic use_wr;
         assign use_wr    = is_write & ext_en[g];
         assign as_arr[g] = use_wr ? wr_as[g*TW +: TW] : rd_as[g*TW +: TW];
         assign ds_arr[g] = use_wr ? wr_ds[g*TW +: TW] : rd_ds[g*TW +: TW];
      end else begin : g_shared
         assign as_arr[g] = rd_as[g*TW +: TW];
         assign ds_arr[g] = rd_ds[g*TW +: TW];
      end
      assign turn_arr[g] = turn[g*TW +: TW];
   end

   assign sel_as   = as_arr[bank_idx];
   assign sel_ds   = ds_arr[bank_idx];
   assign sel_turn = turn_arr[bank_idx];
   assign sel_wide = wide[bank_idx];

endmodule

// File: rtl/xmc_seq.sv
module xmc_seq
   import xmc_pkg::*;
#(
   parameter int NBANK    = 4,
   parameter int DATA_W   = 16,
   parameter int WIN_BITS = 26
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [WIN_BITS-1:0] req_offs,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic                hit,
   input  logic [NBANK-1:0]    hit_vec,
   input  logic [TW-1:0]       sel_as,
   input  logic [TW-1:0]       sel_ds,
   input  logic [TW-1:0]       sel_turn,
   input  logic                sel_wide,
   input  logic [DATA_W-1:0]   mem_dq_in,
   output logic                req_ready,
   output logic                resp_valid,
   output logic                resp_err,
   output logic [DATA_W-1:0]   resp_rdata,
   output logic                ph_addr,
   output logic                ph_data,
   output logic                wr_q,
   output logic [NBANK-1:0]    bank_q,
   output logic [WIN_BITS-1:0] addr_q,
   output logic [DATA_W-1:0]   wdata_q,
   output logic                wide_q
);
   localparam int HALF = DATA_W / 2;

   xmc_state_e     state;
   logic [TW-1:0]  cnt;
   logic [TW-1:0]  dlen_q;
   logic [TW-1:0]  turn_q;
   logic           take;

   assign req_ready = (state == ST_IDLE);
   assign take      = req_ready & req_valid;
   assign ph_addr   = (state == ST_ADDR);
   assign ph_data   = (state == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         dlen_q     <= '0;
         turn_q     <= '0;
         bank_q     <= '0;
         wr_q       <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
         wide_q     <= 1'b0;
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= '0;
      end else begin
         resp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (take) begin
                  if (!hit) begin
                     // miss: answer at once, stay idle, no bus cycle
                     resp_valid <= 1'b1;
                     resp_err   <= 1'b1;
                  end else begin
                     bank_q  <= hit_vec;
                     wr_q    <= req_write;
                     addr_q  <= req_offs;
                     wdata_q <= req_wdata;
                     wide_q  <= sel_wide;
                     dlen_q  <= sel_ds;
                     turn_q  <= sel_turn;
                     if (sel_as != '0) begin
                        state <= ST_ADDR;
                        cnt   <= sel_as - 1'b1;
                     end else begin
                        state <= ST_DATA;
                        cnt   <= sel_ds;
                     end
                  end
               end
            end
            ST_ADDR: begin
               if (cnt == '0) begin
                  state <= ST_DATA;
                  cnt   <= dlen_q;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt == '0) begin
                  resp_valid <= 1'b1;
                  resp_err   <= 1'b0;
                  if (!wr_q) begin
                     resp_rdata <= wide_q ? mem_dq_in
                                          : {{(DATA_W-HALF){1'b0}}, mem_dq_in[HALF-1:0]};
                  end
                  if (turn_q != '0) begin
                     state <= ST_TURN;
                     cnt   <= turn_q - 1'b1;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_TURN: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5: a good completion always follows a strobe cycle
   a_r5_resp_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_err) |-> $past(ph_data));

   // R8: no new access may start while the bus is quiet
   a_r8_no_accept_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TURN) |=> !ph_addr && !ph_data);

endmodule

// File: rtl/xmc_pins.sv
module xmc_pins #(
   parameter int NBANK    = 4,
   parameter int DATA_W   = 16,
   parameter int WIN_BITS = 26
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ph_addr,
   input  logic                ph_data,
   input  logic                wr_q,
   input  logic [NBANK-1:0]    bank_q,
   input  logic [WIN_BITS-1:0] addr_q,
   input  logic [DATA_W-1:0]   wdata_q,
   input  logic                wide_q,
   output logic [NBANK-1:0]    mem_ce_n,
   output logic [WIN_BITS-1:0] mem_a,
   output logic                mem_oe_n,
   output logic                mem_we_n,
   output logic [DATA_W-1:0]   mem_dq_out,
   output logic                mem_dq_drive
);
   localparam int HALF = DATA_W / 2;

   logic active;
   assign active = ph_addr | ph_data;

   for (genvar g = 0; g < NBANK; g++) begin : g_cs
      assign mem_ce_n[g] = ~(active & bank_q[g]);
   end

   // wide windows address halfwords, narrow windows address bytes
   assign mem_a        = wide_q ? {1'b0, addr_q[WIN_BITS-1:1]} : addr_q;
   assign mem_oe_n     = ~(ph_data & ~wr_q);
   assign mem_we_n     = ~(ph_data &  wr_q);
   assign mem_dq_drive = ph_data & wr_q;
   assign mem_dq_out   = wide_q ? wdata_q
                                : {{(DATA_W-HALF){1'b0}}, wdata_q[HALF-1:0]};

   a_r3_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_ce_n));

   a_r11_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   a_r11_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_drive |-> mem_oe_n);

   a_r4_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_we_n) |-> !(&mem_ce_n));

   a_r6_wdata_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_drive && $past(mem_dq_drive)) |-> $stable(mem_dq_out));

endmodule

// File: rtl/xmc_top.sv
module xmc_top
   import xmc_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                DATA_W      = 16,
   parameter int                NBANK       = 4,
   parameter int                WIN_BITS    = 26,
   parameter logic [ADDR_W-1:0] BASE        = 32'h6000_0000,
   parameter bit                EXT_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                resp_valid,
   output logic                resp_err,
   output logic [DATA_W-1:0]   resp_rdata,
   input  logic [NBANK*TW-1:0] cfg_rd_addset,
   input  logic [NBANK*TW-1:0] cfg_rd_datast,
   input  logic [NBANK*TW-1:0] cfg_wr_addset,
   input  logic [NBANK*TW-1:0] cfg_wr_datast,
   input  logic [NBANK*TW-1:0] cfg_turn,
   input  logic [NBANK-1:0]    cfg_ext_wr,
   input  logic [NBANK-1:0]    cfg_wide,
   output logic [NBANK-1:0]    mem_ce_n,
   output logic [WIN_BITS-1:0] mem_a,
   output logic                mem_oe_n,
   output logic                mem_we_n,
   output logic [DATA_W-1:0]   mem_dq_out,
   output logic                mem_dq_drive,
   input  logic [DATA_W-1:0]   mem_dq_in
);
   localparam int BIDX_W = $clog2(NBANK);

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_chk_nbank
      $error("window count must be a power of two, at least 2");
   end
   if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_chk_dw
      $error("data width must be even and at least 8");
   end
   if (WIN_BITS < 2 || WIN_BITS >= ADDR_W) begin : g_chk_win
      $error("window size must lie inside the address width");
   end

   logic [NBANK-1:0]    hit_vec;
   logic [BIDX_W-1:0]   bank_idx;
   logic                hit;
   logic [TW-1:0]       sel_as, sel_ds, sel_turn;
   logic                sel_wide;
   logic                ph_addr, ph_data, wr_q, wide_q;
   logic [NBANK-1:0]    bank_q;
   logic [WIN_BITS-1:0] addr_q;
   logic [DATA_W-1:0]   wdata_q;

   xmc_decode #(
      .ADDR_W(ADDR_W), .NBANK(NBANK), .WIN_BITS(WIN_BITS),
      .BIDX_W(BIDX_W), .BASE(BASE)
   ) u_decode (
      .addr(req_addr), .hit_vec(hit_vec), .bank_idx(bank_idx), .hit(hit)
   );

   xmc_tsel #(
      .NBANK(NBANK), .BIDX_W(BIDX_W), .TW(TW), .EXT_SUPPORT(EXT_SUPPORT)
   ) u_tsel (
      .bank_idx(bank_idx), .is_write(req_write),
      .rd_as(cfg_rd_addset), .rd_ds(cfg_rd_datast),
      .wr_as(cfg_wr_addset), .wr_ds(cfg_wr_datast),
      .turn(cfg_turn), .ext_en(cfg_ext_wr), .wide(cfg_wide),
      .sel_as(sel_as), .sel_ds(sel_ds), .sel_turn(sel_turn), .sel_wide(sel_wide)
   );

   xmc_seq #(
      .NBANK(NBANK), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_offs(req_addr[WIN_BITS-1:0]), .req_wdata(req_wdata),
      .hit(hit), .hit_vec(hit_vec),
      .sel_as(sel_as), .sel_ds(sel_ds), .sel_turn(sel_turn), .sel_wide(sel_wide),
      .mem_dq_in(mem_dq_in),
      .req_ready(req_ready), .resp_valid(resp_valid), .resp_err(resp_err),
      .resp_rdata(resp_rdata),
      .ph_addr(ph_addr), .ph_data(ph_data), .wr_q(wr_q), .bank_q(bank_q),
      .addr_q(addr_q), .wdata_q(wdata_q), .wide_q(wide_q)
   );

   xmc_pins #(
      .NBANK(NBANK), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS)
   ) u_pins (
      .clk(clk), .rst_n(rst_n),
      .ph_addr(ph_addr), .ph_data(ph_data), .wr_q(wr_q), .bank_q(bank_q),
      .addr_q(addr_q), .wdata_q(wdata_q), .wide_q(wide_q),
      .mem_ce_n(mem_ce_n), .mem_a(mem_a), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive)
   );

   // R2: a miss never touches the external bus
   a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_err) |-> (&mem_ce_n) && mem_oe_n && mem_we_n);

   // R8: accepting only while every chip select is released
   a_r8_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&mem_ce_n));

endmodule

// File: tb/xmc_top_tb.sv
module xmc_top_tb;
   localparam int CLK_P = 10;

   logic        clk, rst_n;
   logic        req_valid, req_ready, req_write;
   logic [31:0] req_addr;
   logic [15:0] req_wdata;
   logic        resp_valid, resp_err;
   logic [15:0] resp_rdata;
   logic [15:0] cfg_rd_as, cfg_rd_ds, cfg_wr_as, cfg_wr_ds, cfg_turn;
   logic [3:0]  cfg_ext, cfg_wide;
   logic [3:0]  mem_ce_n;
   logic [25:0] mem_a;
   logic        mem_oe_n, mem_we_n, mem_dq_drive;
   logic [15:0] mem_dq_out, mem_dq_in;

   int n_chk = 0;
   int n_bad = 0;

   xmc_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
      .cfg_rd_addset(cfg_rd_as), .cfg_rd_datast(cfg_rd_ds),
      .cfg_wr_addset(cfg_wr_as), .cfg_wr_datast(cfg_wr_ds),
      .cfg_turn(cfg_turn), .cfg_ext_wr(cfg_ext), .cfg_wide(cfg_wide),
      .mem_ce_n(mem_ce_n), .mem_a(mem_a), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
      .mem_dq_in(mem_dq_in)
   );

   // memory model: returns data only while the read strobe is low
   function automatic logic [15:0] model(input logic [25:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction
   assign mem_dq_in = !mem_oe_n ? model(mem_a) : 16'hDEAD;

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(input int b, input int ras, input int rds, input int was,
                          input int wds, input int t, input bit ext, input bit wide);
      cfg_rd_as[b*4 +: 4] = 4'(ras);
      cfg_rd_ds[b*4 +: 4] = 4'(rds);
      cfg_wr_as[b*4 +: 4] = 4'(was);
      cfg_wr_ds[b*4 +: 4] = 4'(wds);
      cfg_turn[b*4 +: 4]  = 4'(t);
      cfg_ext[b]          = ext;
      cfg_wide[b]         = wide;
   endtask

   task automatic xfer(input bit wr, input logic [31:0] addr, input logic [15:0] wd);
      bit inwin, wide_e, ext_e, seen, bad_cs, bad_multi, bad_a, bad_dq, bad_drv, bad_both;
      int b, as_e, ds_e, t_e, n, n_ce, n_pre, n_oe, n_we, n_rdy;
      logic [25:0] a_e;
      logic [15:0] dq_e, rd_e, mv;
      string tag;
      inwin  = (addr >= 32'h6000_0000) && (addr <= 32'h6FFF_FFFF);
      b      = inwin ? int'((addr - 32'h6000_0000) >> 26) : 0;
      wide_e = cfg_wide[b];
      ext_e  = cfg_ext[b];
      as_e   = (wr && ext_e) ? int'(cfg_wr_as[b*4 +: 4]) : int'(cfg_rd_as[b*4 +: 4]);
      ds_e   = (wr && ext_e) ? int'(cfg_wr_ds[b*4 +: 4]) : int'(cfg_rd_ds[b*4 +: 4]);
      t_e    = inwin ? int'(cfg_turn[b*4 +: 4]) : 0;
      a_e    = wide_e ? {1'b0, addr[25:1]} : addr[25:0];
      dq_e   = wide_e ? wd : {8'h00, wd[7:0]};
      mv     = model(a_e);
      rd_e   = wide_e ? mv : {8'h00, mv[7:0]};
      tag    = wr ? "R7" : "R4";
      seen = 0; bad_cs = 0; bad_multi = 0; bad_a = 0; bad_dq = 0; bad_drv = 0; bad_both = 0;
      n = 0; n_ce = 0; n_pre = 0; n_oe = 0; n_we = 0; n_rdy = 0;

      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!resp_valid && n < 100) begin
         if (mem_ce_n != 4'hF) begin
            n_ce++;
            if (mem_ce_n != ~(4'b0001 << b)) bad_cs = 1;
            if (mem_a != a_e) bad_a = 1;
            if (mem_oe_n && mem_we_n && !seen) n_pre++;
         end
         if ($countones(~mem_ce_n) > 1) bad_multi = 1;
         if (!mem_oe_n) begin n_oe++; seen = 1; end
         if (!mem_we_n) begin n_we++; seen = 1; end
         if (!mem_oe_n && (!mem_we_n || mem_dq_drive)) bad_both = 1;
         if (mem_dq_drive != !mem_we_n) bad_drv = 1;
         if (mem_dq_drive && mem_dq_out != dq_e) bad_dq = 1;
         n++;
         @(negedge clk);
      end
      chk(resp_valid, "R5", "response seen", resp_valid, 1);
      chk(resp_err == !inwin, "R2", "error flag", resp_err, !inwin);
      chk(mem_ce_n == 4'hF, "R4", "chip select released at response", mem_ce_n, 4'hF);
      chk(!bad_multi, "R3", "several chip selects low", 1, 0);
      chk(!bad_both, "R11", "read strobe overlaps write/drive", 1, 0);
      if (!inwin) begin
         chk(n_ce == 0 && n_oe == 0 && n_we == 0, "R2", "bus cycles on miss",
             n_ce + n_oe + n_we, 0);
         chk(n == 0, "R2", "miss response delay", n, 0);
      end else begin
         chk(!bad_cs, "R1", "chip select pattern", b, b);
         chk(!bad_a, "R9", "external address", 1, 0);
         chk(n_pre == as_e, tag, "address phase cycles", n_pre, as_e);
         chk(n_ce == as_e + ds_e + 1, tag, "chip select cycles", n_ce, as_e + ds_e + 1);
         if (wr) begin
            chk(n_we == ds_e + 1 && n_oe == 0, "R6", "write strobe cycles", n_we, ds_e + 1);
            chk(!bad_dq && !bad_drv, "R6", "write data drive", {bad_dq, bad_drv}, 0);
         end else begin
            chk(n_oe == ds_e + 1 && n_we == 0, "R4", "read strobe cycles", n_oe, ds_e + 1);
            chk(resp_rdata == rd_e, "R5", "read data", resp_rdata, rd_e);
            if (!wide_e)
               chk(resp_rdata[15:8] == 8'h00, "R9", "narrow upper byte", resp_rdata, rd_e);
         end
      end
      while (!req_ready && n_rdy < 40) begin
         n_rdy++;
         @(negedge clk);
      end
      chk(n_rdy == t_e, "R8", "quiet gap cycles", n_rdy, t_e);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] offs [5];
      logic [31:0] miss [5];
      offs[0] = 32'h0000_0000; offs[1] = 32'h0000_0002; offs[2] = 32'h0012_3457;
      offs[3] = 32'h03FF_FFFE; offs[4] = 32'h03FF_FFFF;
      miss[0] = 32'h5FFF_FFFF; miss[1] = 32'h7000_0000; miss[2] = 32'h0000_0000;
      miss[3] = 32'hFFFF_FFFF; miss[4] = 32'h5000_0000;

      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      cfg_rd_as = '0; cfg_rd_ds = '0; cfg_wr_as = '0; cfg_wr_ds = '0; cfg_turn = '0;
      cfg_ext = '0; cfg_wide = '0;
      set_cfg(0, 1, 2, 3, 0, 2, 1'b1, 1'b1);
      set_cfg(1, 0, 0, 5, 5, 0, 1'b0, 1'b1);   // write pair must be ignored (R7)
      set_cfg(2, 2, 1, 0, 3, 1, 1'b1, 1'b0);   // narrow window
      set_cfg(3, 15, 15, 4, 1, 3, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      chk(mem_ce_n == 4'hF && mem_oe_n && mem_we_n && !mem_dq_drive, "R10",
          "bus idle in reset", mem_ce_n, 4'hF);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !resp_valid, "R10", "ready after reset", {req_ready, resp_valid}, 2'b10);
      chk(mem_ce_n == 4'hF && !mem_dq_drive, "R10", "bus idle after reset", mem_ce_n, 4'hF);

      // every window, window edges, both directions
      for (int b = 0; b < 4; b++) begin
         for (int k = 0; k < 5; k++) begin
            xfer(1'b0, 32'h6000_0000 + (32'(b) << 26) + offs[k], 16'h0);
            xfer(1'b1, 32'h6000_0000 + (32'(b) << 26) + offs[k],
                 16'hC3A0 ^ 16'(b * 16'h1111) ^ 16'(k));
         end
      end
      // addresses outside every window
      for (int k = 0; k < 5; k++) begin
         xfer(1'b0, miss[k], 16'h0);
         xfer(1'b1, miss[k], 16'hBEEF);
      end
      // timing sweep on window 1, separate write pair enabled
      for (int as = 0; as < 16; as++) begin
         for (int j = 0; j < 4; j++) begin
            int ds;
            ds = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 7 : 15;
            @(negedge clk);
            set_cfg(1, as, ds, 15 - as, 15 - ds, (as + j) % 16, 1'b1, j[0]);
            xfer(1'b0, 32'h6400_0100 + 32'(as * 6 + j), 16'h0);
            xfer(1'b1, 32'h6400_0201 + 32'(as * 6 + j), 16'(as * 257 + j * 4099));
         end
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule